// File: doc/BRIEF.md
# Chained DMA descriptor engine

This block moves blocks of memory without processor involvement by walking a linked list of transfer descriptors held in memory. Software writes the address of the first descriptor into the current-descriptor pointer and writes the start bit. The engine then repeats three steps until the chain ends:

- it fetches the descriptor's four words (source, destination, next pointer, byte count) into its working registers;
- it copies the requested number of bytes one 32-bit word at a time, each word being a read followed by a write;
- it follows the next pointer.

Bit 0 of a next pointer marks the last descriptor. When that descriptor's copy is finished the engine stops and raises a done flag. An error response on any memory access aborts the chain at once. The engine then raises an error flag and freezes its working registers, so software can see how far the transfer got.

There is one word-wide memory master port with a request/acknowledge handshake and an error response. There is also a small register port for the pointer, the start bit, the status word and readback of the working registers.

Top module: `dma_chain_engine`

## Requirements
- R1: The current-descriptor pointer (register select 0) takes the written value only while the engine is idle. Writes made while busy leave it unchanged.
- R2: A descriptor is fetched as four word reads, in this order: base+0x00 (source), base+0x08 (destination), base+0x10 (next pointer), base+0x18 (byte count). The base is the pointer with its low five bits cleared.
- R3: The fetched fields load the source, destination, next-pointer and byte-count registers, readable at selects 3, 4, 5 and 6. The two low bits of the byte count are cleared on load.
- R4: For each word the engine reads the source address and then writes the word read to the destination address. After each write, source and destination advance by 4 and the count drops by 4, until the count reaches zero.
- R5: After a descriptor whose next pointer has bit 0 clear, the next fetch starts at that pointer with its low five bits cleared. The current-descriptor pointer takes that value.
- R6: After the descriptor whose next pointer has bit 0 set, the engine issues no further access, clears busy and sets done.
- R7: An error response on any access sets the error flag, clears busy and stops all requests. The working registers keep the values they held at the failing access.
- R8: The status word at select 2 carries busy in bit 0, done in bit 1 and error in bit 2. Writing 1 to bit 1 or bit 2 clears that flag; writing 0 leaves it.
- R9: Writing select 1 with bit 0 set starts the engine when idle. The same write while busy has no effect on the access sequence.
- R10: A descriptor with a byte count below 4 moves no data and the chain continues normally.
- R11: Once raised, a request holds its address, write flag and write data stable until it is acknowledged or answered with an error.
- R12: After reset, busy, done and error are 0, no request is raised, and the pointer and working registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 3 | Register select: 0 pointer, 1 control, 2 status, 3 source, 4 destination, 5 next pointer, 6 byte count |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Byte address of the access |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access ended in an error |

## Verification
The bench builds the engine with its default 32-bit address width, so every 32-byte aligned descriptor slot in a 4 KB memory model is reachable. That range also covers pointers that carry junk in their low bits. The memory model's acknowledge latency is varied between one and three cycles across runs, which exercises the request-hold rule and back-to-back read/write turnaround. An injected error on a chosen data write checks the frozen register values and the silence on the bus that follows.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int FIELD_SHIFT = 3;                      // fields sit 8 bytes apart
  localparam int FIELD_IDX_W = 2;                      // four fields per descriptor
  localparam int DESC_ALIGN  = FIELD_SHIFT + FIELD_IDX_W;
  localparam int SEL_W       = 3;

  localparam logic [SEL_W-1:0] SEL_CDP  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_SRC  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DST  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_NDP  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_BCNT = 3'd6;

  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
  localparam int STAT_ERR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_NEXT
  } seq_state_e;

endpackage

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     cdp_i,
  output logic              cdp_load_o,
  output logic [AW-1:0]     cdp_next_o,
  output logic              set_done_o,
  output logic              set_err_o,
  output logic              busy_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [AW-1:0]     ndp_o,
  output logic [WORD_W-1:0] bcnt_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i
);

  localparam logic [FIELD_IDX_W-1:0] IDX_LAST = '1;
  localparam logic [WORD_W-1:0]      STEP_W   = WORD_W'(WORD_BYTES);
  localparam logic [AW-1:0]          STEP_A   = AW'(WORD_BYTES);

  seq_state_e              state_q, state_d;
  logic [FIELD_IDX_W-1:0]  idx_q, idx_d;
  logic [AW-1:0]           src_q, src_d, dst_q, dst_d, ndp_q, ndp_d;
  logic [WORD_W-1:0]       bcnt_q, bcnt_d, data_q, data_d;
  logic                    src_en, dst_en, ndp_en, bcnt_en, data_en;
  logic [WORD_W-1:0]       cnt_masked;

  assign cnt_masked = {mem_rdata_i[WORD_W-1:2], 2'b00};

  // next-state process
  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    src_d      = src_q;
    dst_d      = dst_q;
    ndp_d      = ndp_q;
    bcnt_d     = bcnt_q;
    data_d     = data_q;
    src_en     = 1'b0;
    dst_en     = 1'b0;
    ndp_en     = 1'b0;
    bcnt_en    = 1'b0;
    data_en    = 1'b0;
    cdp_load_o = 1'b0;
    set_done_o = 1'b0;
    set_err_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FETCH;
          idx_d   = '0;
        end
      end
      ST_FETCH: begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = ST_IDLE;
        end else if (mem_ack_i) begin
          unique case (idx_q)
            2'd0: begin src_en  = 1'b1; src_d  = mem_rdata_i[AW-1:0]; end
            2'd1: begin dst_en  = 1'b1; dst_d  = mem_rdata_i[AW-1:0]; end
            2'd2: begin ndp_en  = 1'b1; ndp_d  = mem_rdata_i[AW-1:0]; end
            default: begin bcnt_en = 1'b1; bcnt_d = cnt_masked; end
          endcase
          if (idx_q == IDX_LAST) begin
            state_d = (cnt_masked == '0) ? ST_NEXT : ST_READ;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_READ: begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = ST_IDLE;
        end else if (mem_ack_i) begin
          data_en = 1'b1;
          data_d  = mem_rdata_i;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = ST_IDLE;
        end else if (mem_ack_i) begin
          src_en  = 1'b1;
          dst_en  = 1'b1;
          bcnt_en = 1'b1;
          src_d   = src_q + STEP_A;
          dst_d   = dst_q + STEP_A;
          bcnt_d  = bcnt_q - STEP_W;
          state_d = (bcnt_q == STEP_W) ? ST_NEXT : ST_READ;
        end
      end
      ST_NEXT: begin
        if (ndp_q[0]) begin
          set_done_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          cdp_load_o = 1'b1;
          idx_d      = '0;
          state_d    = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      ndp_q   <= '0;
      bcnt_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (ndp_en)  ndp_q  <= ndp_d;
      if (bcnt_en) bcnt_q <= bcnt_d;
      if (data_en) data_q <= data_d;
    end
  end

  // memory port
  always_comb begin
    unique case (state_q)
      ST_FETCH: mem_addr_o = {cdp_i[AW-1:DESC_ALIGN], idx_q, {FIELD_SHIFT{1'b0}}};
      ST_READ:  mem_addr_o = src_q;
      ST_WRITE: mem_addr_o = dst_q;
      default:  mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = data_q;
  assign cdp_next_o  = {ndp_q[AW-1:DESC_ALIGN], {DESC_ALIGN{1'b0}}};
  assign busy_o      = (state_q != ST_IDLE);
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign ndp_o       = ndp_q;
  assign bcnt_o      = bcnt_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !mem_err_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R11
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |-> (!mem_we_o && mem_addr_o[FIELD_SHIFT-1:0] == '0)); // R2
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_err_i) |=> (!mem_req_o && !busy_o)); // R7
  AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (bcnt_q != '0)); // R10

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wen_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              cdp_load_i,
  input  logic [AW-1:0]     cdp_next_i,
  input  logic              set_done_i,
  input  logic              set_err_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [AW-1:0]     ndp_i,
  input  logic [WORD_W-1:0] bcnt_i,
  output logic              start_o,
  output logic [AW-1:0]     cdp_o
);

  logic [AW-1:0] cdp_q, cdp_d;
  logic          cdp_en;
  logic          done_q, done_d, err_q, err_d;
  logic          stat_wr;

  assign stat_wr = wen_i && (sel_i == SEL_STAT);
  assign start_o = wen_i && (sel_i == SEL_CTRL) && wdata_i[0] && !busy_i;

  // next-state process
  always_comb begin
    cdp_en = 1'b0;
    cdp_d  = cdp_q;
    if (cdp_load_i) begin
      cdp_en = 1'b1;
      cdp_d  = cdp_next_i;
    end else if (wen_i && (sel_i == SEL_CDP) && !busy_i) begin
      cdp_en = 1'b1;
      cdp_d  = wdata_i[AW-1:0];
    end
    done_d = done_q;
    err_d  = err_q;
    if (stat_wr && wdata_i[STAT_DONE]) done_d = 1'b0;
    if (stat_wr && wdata_i[STAT_ERR])  err_d  = 1'b0;
    if (set_done_i) done_d = 1'b1;
    if (set_err_i)  err_d  = 1'b1;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cdp_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cdp_en) cdp_q <= cdp_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CDP:  rdata_o = WORD_W'(cdp_q);
      SEL_STAT: begin
        rdata_o[STAT_BUSY] = busy_i;
        rdata_o[STAT_DONE] = done_q;
        rdata_o[STAT_ERR]  = err_q;
      end
      SEL_SRC:  rdata_o = WORD_W'(src_i);
      SEL_DST:  rdata_o = WORD_W'(dst_i);
      SEL_NDP:  rdata_o = WORD_W'(ndp_i);
      SEL_BCNT: rdata_o = bcnt_i;
      default:  rdata_o = '0;
    endcase
  end

  assign cdp_o = cdp_q;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_done_i |=> done_q); // R6
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_err_i |=> err_q); // R7
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata_i[STAT_DONE] && !set_done_i) |=> !done_q); // R8
  AST_CDP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !cdp_load_i) |=> $stable(cdp_q)); // R1

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wen,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);

  logic          rst_meta_q, rst_sync_q;
  logic          start, busy, cdp_load, set_done, set_err;
  logic [AW-1:0] cdp, cdp_next, src, dst, ndp;
  logic [WORD_W-1:0] bcnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dmac_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .sel_i      (reg_sel),
    .wen_i      (reg_wen),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .busy_i     (busy),
    .cdp_load_i (cdp_load),
    .cdp_next_i (cdp_next),
    .set_done_i (set_done),
    .set_err_i  (set_err),
    .src_i      (src),
    .dst_i      (dst),
    .ndp_i      (ndp),
    .bcnt_i     (bcnt),
    .start_o    (start),
    .cdp_o      (cdp)
  );

  dmac_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start_i     (start),
    .cdp_i       (cdp),
    .cdp_load_o  (cdp_load),
    .cdp_next_o  (cdp_next),
    .set_done_o  (set_done),
    .set_err_o   (set_err),
    .busy_o      (busy),
    .src_o       (src),
    .dst_o       (dst),
    .ndp_o       (ndp),
    .bcnt_o      (bcnt),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_ack_i   (mem_ack),
    .mem_err_i   (mem_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |=> (!mem_req && !busy)); // R12

endmodule

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        reg_wen;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  dma_chain_engine u_dma_chain_engine (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem [0:1023];
  int          lat;
  logic [31:0] err_addr;
  bit          err_on;

  // expected access list and expected final working registers
  logic [31:0] q_addr[$];
  bit          q_we[$];
  logic [31:0] q_data[$];
  logic [31:0] e_src, e_dst, e_ndp, e_cnt, e_cdp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int widx(input logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  // behavioural walk of the chain over the current memory image
  task automatic build(input logic [31:0] start_ptr);
    logic [31:0] base, s, d, nx, c;
    bit stop;
    q_addr.delete(); q_we.delete(); q_data.delete();
    base = start_ptr & 32'hFFFF_FFE0;
    stop = 0;
    s = 0; d = 0; nx = 0; c = 0;
    e_cdp = start_ptr;
    while (!stop) begin
      for (int f = 0; f < 4 && !stop; f++) begin
        q_addr.push_back(base + 32'(f * 8)); q_we.push_back(0); q_data.push_back(0);
        if (err_on && base + 32'(f * 8) == err_addr) stop = 1;
        else if (f == 0) s = mem[widx(base)];
        else if (f == 1) d = mem[widx(base + 8)];
        else if (f == 2) nx = mem[widx(base + 16)];
        else c = mem[widx(base + 24)] & 32'hFFFF_FFFC;
      end
      while (!stop && c != 0) begin
        q_addr.push_back(s); q_we.push_back(0); q_data.push_back(0);
        if (err_on && s == err_addr) begin stop = 1; break; end
        q_addr.push_back(d); q_we.push_back(1); q_data.push_back(mem[widx(s)]);
        if (err_on && d == err_addr) begin stop = 1; break; end
        s += 4; d += 4; c -= 4;
      end
      if (!stop) begin
        if (nx[0]) stop = 1;
        else begin base = nx & 32'hFFFF_FFE0; e_cdp = base; end
      end
    end
    e_src = s; e_dst = d; e_ndp = nx; e_cnt = c;
  endtask

  // memory model with programmable latency; compares every completed access
  int          wcnt;
  logic [31:0] h_addr, h_wdata;
  logic        h_we;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0; wcnt = 0;
    end else if (mem_ack || mem_err) begin
      mem_ack <= 0; mem_err <= 0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        h_addr = mem_addr; h_we = mem_we; h_wdata = mem_wdata;
      end else begin
        chk("R11 request hold", {mem_addr[31:1], 1'b0} ^ {h_addr[31:1], 1'b0} |
            ((mem_we != h_we) || (h_we && mem_wdata != h_wdata) ? 32'h1 : 32'h0), 32'h0);
      end
      wcnt++;
      if (wcnt >= lat) begin
        if (q_addr.size() == 0) begin
          chk("R6 unexpected access", mem_addr, 32'hDEAD_BEEF);
        end else begin
          chk("R2/R5 access address", mem_addr, q_addr[0]);
          chk("R4 access direction", {31'b0, mem_we}, {31'b0, q_we[0]});
          if (q_we[0]) chk("R4 write data", mem_wdata, q_data[0]);
          void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
        end
        if (err_on && mem_addr == err_addr) mem_err <= 1;
        else begin
          mem_ack <= 1;
          if (mem_we) mem[widx(mem_addr)] = mem_wdata;
          else mem_rdata <= mem[widx(mem_addr)];
        end
      end
    end
  end

  task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wen = 1;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic reg_read(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 5000; i++) begin
      reg_read(3'd2, st);
      if (!st[0]) return;
    end
    chk("R6 busy never cleared", 32'h1, 32'h0);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] nx, input logic [31:0] c);
    mem[widx(at)] = s; mem[widx(at + 8)] = d;
    mem[widx(at + 16)] = nx; mem[widx(at + 24)] = c;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] v;
    reg_read(3'd3, v); chk({tag, " R3 source"}, v, e_src);
    reg_read(3'd4, v); chk({tag, " R3 destination"}, v, e_dst);
    reg_read(3'd5, v); chk({tag, " R3 next pointer"}, v, e_ndp);
    reg_read(3'd6, v); chk({tag, " R3 byte count"}, v, e_cnt);
    chk({tag, " R4 leftover accesses"}, 32'(q_addr.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL R6 watchdog: busy actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; reg_sel = 0; reg_wen = 0; reg_wdata = 0;
    lat = 2; err_on = 0; err_addr = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R12 reset state
    reg_read(3'd2, v); chk("R12 status", v, 32'h0);
    reg_read(3'd0, v); chk("R12 pointer", v, 32'h0);
    reg_read(3'd6, v); chk("R12 byte count", v, 32'h0);
    chk("R12 request", {31'b0, mem_req}, 32'h0);

    // three-descriptor chain: junk low bits in a pointer, a zero count, an unaligned count
    for (int i = 0; i < 4; i++) mem[widx(32'h800 + 32'(4 * i))] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 2; i++) mem[widx(32'h900 + 32'(4 * i))] = 32'hB000_0010 + 32'(i);
    put_desc(32'h100, 32'h800, 32'hC00, 32'h144, 32'd12);
    put_desc(32'h140, 32'h880, 32'hC80, 32'h1A0, 32'd0);
    put_desc(32'h1A0, 32'h900, 32'hD00, 32'h001, 32'h0B);
    reg_write(3'd0, 32'h100);
    reg_read(3'd0, v); chk("R1 pointer write while idle", v, 32'h100);
    build(32'h100);
    reg_write(3'd1, 32'h1);                      // R9 start
    reg_write(3'd0, 32'h3E0);                    // R1 ignored while busy
    reg_write(3'd1, 32'h1);                      // R9 ignored while busy
    wait_idle();
    reg_read(3'd2, v); chk("R6 done after last descriptor", v, 32'h2);
    reg_read(3'd0, v); chk("R1/R5 pointer follows chain", v, e_cdp);
    check_regs("chain");
    for (int i = 0; i < 3; i++)
      chk("R4 copied word", mem[widx(32'hC00 + 32'(4 * i))], 32'hA000_0000 + 32'(i));
    chk("R4 word past count untouched", mem[widx(32'hC0C)], 32'h0);
    chk("R10 zero-count destination untouched", mem[widx(32'hC80)], 32'h0);
    for (int i = 0; i < 2; i++)
      chk("R3 masked count copy", mem[widx(32'hD00 + 32'(4 * i))], 32'hB000_0010 + 32'(i));

    // R8 write-one-to-clear
    reg_write(3'd2, 32'h0);
    reg_read(3'd2, v); chk("R8 writing 0 keeps done", v, 32'h2);
    reg_write(3'd2, 32'h2);
    reg_read(3'd2, v); chk("R8 writing 1 clears done", v, 32'h0);

    // R7 error on the third data write, latency 1
    lat = 1;
    for (int i = 0; i < 4; i++) mem[widx(32'hA00 + 32'(4 * i))] = 32'h5500_0000 + 32'(i);
    put_desc(32'h200, 32'hA00, 32'hE00, 32'h001, 32'd16);
    err_on = 1; err_addr = 32'hE08;
    reg_write(3'd0, 32'h200);
    build(32'h200);
    reg_write(3'd1, 32'h1);
    wait_idle();
    reg_read(3'd2, v); chk("R7 error flag, no done", v, 32'h4);
    check_regs("error");
    chk("R7 failing word not written", mem[widx(32'hE08)], 32'h0);
    chk("R4 word before failure written", mem[widx(32'hE04)], 32'h5500_0001);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 no request after error", {31'b0, mem_req}, 32'h0);
    end
    err_on = 0;
    reg_write(3'd2, 32'h4);
    reg_read(3'd2, v); chk("R8 writing 1 clears error", v, 32'h0);

    // R10 single zero-count end descriptor, latency 3
    lat = 3;
    put_desc(32'h2E0, 32'hF00, 32'hF80, 32'h001, 32'd3);
    reg_write(3'd0, 32'h2E0);
    build(32'h2E0);
    reg_write(3'd1, 32'h1);
    wait_idle();
    reg_read(3'd2, v); chk("R10 zero count completes with done", v, 32'h2);
    check_regs("zero");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule